// File: doc/BRIEF.md
# I2C Bus Timing Word Calculator

This block converts a requested I2C bus rate, given in hertz, into the three timing words that program an SCL generator running from a 24 MHz block clock. A single-cycle `start` pulse captures the rate. The block then runs a short sequence of integer divisions on one shared restoring divider. It reports the result with a one-cycle `done` pulse and holds the words until the next result. A `clamped` flag tells the caller that the requested rate was out of range and was replaced by the nearest rate the generator can produce.

The calculation has these stages. First, a period count in block-clock cycles is formed by rounding up. That count is limited to a legal window. It is then split into an SCL low time and an SCL high time using one of two low:high ratios, chosen by bus mode. Sample and drive points are placed at three eighths of the high and low times. Fixed start lead-in and bus-idle counts are attached for the mode. The generator adds a fixed overhead to the low and high phases, so that overhead is subtracted from both before the words are packed.

The control sequence has five states. CS_IDLE waits for `start`. It moves to CS_RATE_DIV for a nonzero rate, or directly to CS_SETUP for a zero rate. CS_RATE_DIV moves to CS_SETUP when the divider returns. CS_SETUP always moves to CS_LOW_DIV. CS_LOW_DIV moves to CS_HIGH_DIV when the divider returns. CS_HIGH_DIV moves back to CS_IDLE when the divider returns, and at that point the outputs are written and `done` is raised.

Top module: `i2c_tcalc`

## Requirements
- R1: For a nonzero rate S, the period count P is the rounded-up quotient of 24,000,000 by S.
- R2: P is limited to the range 25..1897. `clamped` is 1 exactly when P fell outside that range. A later in-range request clears `clamped`.
- R3: A rate of 0 selects P = 1897 with `clamped` = 1, and no division by the rate takes place.
- R4: A rate strictly above 100,000 selects fast mode. In fast mode, low = floor((13·P + 9)/19) and high = floor((6·P + 9)/19), which is division rounded to nearest.
- R5: A rate of 100,000 or below selects standard mode. In standard mode, low = floor((47·P + 43)/87) and high = floor((40·P + 43)/87).
- R6: The receive point is floor(3·high/8) and the transmit point is floor(3·low/8). Both are taken from the counts before the overhead is removed.
- R7: In fast mode, lead-in = 15 and bus-idle = 32. In standard mode, both are 113.
- R8: `hi_word` is {high−7 in bits 31:16, receive point in bits 15:0}. `lo_word` is {low−2 in bits 31:16, transmit point in bits 15:0}. `gap_word` is {bus-idle in bits 31:16, lead-in in bits 15:0}.
- R9: Each accepted request produces exactly one `done` pulse, one cycle long. The words and `clamped` change only in the cycle `done` rises, and hold their values afterwards.
- R10: A `start` that arrives while a calculation is running is ignored. The running result is unaffected and no extra `done` is produced.
- R11: After reset, `done`, `clamped` and all three words are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse; captures `speed_hz` when idle |
| speed_hz | input | 32 | Requested bus rate in Hz |
| done | output | 1 | One-cycle pulse when the words are valid |
| clamped | output | 1 | Period count was forced to a limit |
| hi_word | output | 32 | Corrected high count and receive point |
| lo_word | output | 32 | Corrected low count and transmit point |
| gap_word | output | 32 | Bus-idle and lead-in counts |

## Verification
Several properties are checked on every cycle by the bound checker:
- `done` is a single-cycle pulse.
- Outputs never move outside a `done` cycle.
- Every `done` follows an accepted request.
- `gap_word` matches the mode implied by the captured rate.
- The clamp flag agrees with an exact range test on that rate.
- Sample points never exceed their uncorrected counts.

The exact divider rounding, the 13:6 and 47:40 splits, the mode boundary at 100,000 versus 100,001, and the clamp edges (960,000 against 1,000,000, and 12,652 against 12,651) can only be shown by the bench's directed scenarios. The same holds for the rejection of a second request during a calculation.

// File: rtl/i2c_tcalc_pkg.sv
package i2c_tcalc_pkg;

    // Sequencer states of the timing calculator
    typedef enum logic [2:0] {
        CS_IDLE,
        CS_RATE_DIV,
        CS_SETUP,
        CS_LOW_DIV,
        CS_HIGH_DIV
    } calc_state_e;

endpackage

// File: rtl/i2c_tcalc_div.sv
// Restoring unsigned divider: one quotient bit per cycle, W steps per divide.
module i2c_tcalc_div #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] quot,
    output logic [W-1:0] rem,
    output logic         valid
);
    localparam int CNT_W = $clog2(W + 1);

    logic [W-1:0]     quo_q;
    logic [W-1:0]     rem_q;
    logic [W-1:0]     dvs_q;
    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;
    logic             valid_q;
    logic [W:0]       trial;

    // Partial remainder shifted by one bit, minus the divisor
    always_comb begin
        trial = {rem_q, quo_q[W-1]} - {1'b0, dvs_q};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quo_q   <= '0;
            rem_q   <= '0;
            dvs_q   <= '0;
            cnt_q   <= '0;
            busy_q  <= 1'b0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (go && !busy_q) begin
                quo_q  <= dividend;
                rem_q  <= '0;
                dvs_q  <= divisor;
                cnt_q  <= CNT_W'(W);
                busy_q <= 1'b1;
            end else if (busy_q) begin
                if (!trial[W]) begin
                    rem_q <= trial[W-1:0];
                    quo_q <= {quo_q[W-2:0], 1'b1};
                end else begin
                    rem_q <= {rem_q[W-2:0], quo_q[W-1]};
                    quo_q <= {quo_q[W-2:0], 1'b0};
                end
                cnt_q <= cnt_q - CNT_W'(1);
                if (cnt_q == CNT_W'(1)) begin
                    busy_q  <= 1'b0;
                    valid_q <= 1'b1;
                end
            end
        end
    end

    assign quot  = quo_q;
    assign rem   = rem_q;
    assign valid = valid_q;

endmodule

// File: rtl/i2c_tcalc_ratio.sv
// Forms the rounded-to-nearest numerators and the shared denominator
// that split the period count into low and high phases.
module i2c_tcalc_ratio #(
    parameter int W       = 32,
    parameter int DIVW    = 11,
    parameter int FAST_LO = 13,
    parameter int FAST_HI = 6,
    parameter int STD_LO  = 47,
    parameter int STD_HI  = 40
) (
    input  logic            fast,
    input  logic [DIVW-1:0] period,
    output logic [W-1:0]    low_num,
    output logic [W-1:0]    high_num,
    output logic [W-1:0]    den
);
    localparam int FAST_DEN = FAST_LO + FAST_HI;
    localparam int STD_DEN  = STD_LO + STD_HI;

    logic [W-1:0] lo_w;
    logic [W-1:0] hi_w;
    logic [W-1:0] half;

    always_comb begin
        if (fast) begin
            lo_w = W'(FAST_LO);
            hi_w = W'(FAST_HI);
            den  = W'(FAST_DEN);
            half = W'(FAST_DEN / 2);
        end else begin
            lo_w = W'(STD_LO);
            hi_w = W'(STD_HI);
            den  = W'(STD_DEN);
            half = W'(STD_DEN / 2);
        end
        low_num  = W'(period) * lo_w + half;
        high_num = W'(period) * hi_w + half;
    end

endmodule

// File: rtl/i2c_tcalc_pack.sv
// Derives sample points, removes generator overhead and packs the three words.
module i2c_tcalc_pack #(
    parameter int CW           = 16,
    parameter int LOW_OVH      = 2,
    parameter int HIGH_OVH     = 7,
    parameter int LEADIN_FAST  = 15,
    parameter int BUSFREE_FAST = 32,
    parameter int LEADIN_STD   = 113,
    parameter int BUSFREE_STD  = 113
) (
    input  logic          fast,
    input  logic [CW-1:0] low_cnt,
    input  logic [CW-1:0] high_cnt,
    output logic [2*CW-1:0] hi_word,
    output logic [2*CW-1:0] lo_word,
    output logic [2*CW-1:0] gap_word
);
    logic [CW-1:0] rcv_pt;
    logic [CW-1:0] xmit_pt;
    logic [CW-1:0] leadin;
    logic [CW-1:0] busfree;

    always_comb begin
        rcv_pt  = CW'(({2'b00, high_cnt} * (CW+2)'(3)) >> 3);
        xmit_pt = CW'(({2'b00, low_cnt} * (CW+2)'(3)) >> 3);
        leadin  = fast ? CW'(LEADIN_FAST)  : CW'(LEADIN_STD);
        busfree = fast ? CW'(BUSFREE_FAST) : CW'(BUSFREE_STD);
        hi_word  = {high_cnt - CW'(HIGH_OVH), rcv_pt};
        lo_word  = {low_cnt - CW'(LOW_OVH), xmit_pt};
        gap_word = {busfree, leadin};
    end

endmodule

// File: rtl/i2c_tcalc.sv
module i2c_tcalc
    import i2c_tcalc_pkg::*;
#(
    parameter int SPEED_W         = 32,
    parameter int FIELD_W         = 16,
    parameter int CLK_HZ          = 24_000_000,
    parameter int DIV_MIN         = 25,
    parameter int DIV_MAX         = 1897,
    parameter int FAST_ABOVE_HZ   = 100_000,
    parameter int FAST_LO         = 13,
    parameter int FAST_HI         = 6,
    parameter int STD_LO          = 47,
    parameter int STD_HI          = 40,
    parameter int LOW_OVH         = 2,
    parameter int HIGH_OVH        = 7,
    parameter int FAST_LEADIN_NS  = 600,
    parameter int FAST_BUSFREE_NS = 1300,
    parameter int STD_LEADIN_NS   = 4700,
    parameter int STD_BUSFREE_NS  = 4700
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [SPEED_W-1:0]   speed_hz,
    output logic                 done,
    output logic                 clamped,
    output logic [2*FIELD_W-1:0] hi_word,
    output logic [2*FIELD_W-1:0] lo_word,
    output logic [2*FIELD_W-1:0] gap_word
);
    localparam int DIVW         = $clog2(DIV_MAX + 1);
    localparam int CLK_MHZ      = CLK_HZ / 1_000_000;
    localparam int LEADIN_FAST  = (FAST_LEADIN_NS * CLK_MHZ + 999) / 1000;
    localparam int BUSFREE_FAST = (FAST_BUSFREE_NS * CLK_MHZ + 999) / 1000;
    localparam int LEADIN_STD   = (STD_LEADIN_NS * CLK_MHZ + 999) / 1000;
    localparam int BUSFREE_STD  = (STD_BUSFREE_NS * CLK_MHZ + 999) / 1000;

    calc_state_e state_q, state_d;

    logic               div_go;
    logic [SPEED_W-1:0] div_dividend;
    logic [SPEED_W-1:0] div_divisor;
    logic [SPEED_W-1:0] div_quot;
    logic [SPEED_W-1:0] div_rem;
    logic               div_valid;
    logic [SPEED_W-1:0] period_raw;

    logic               fast_q;
    logic               clamp_q;
    logic [DIVW-1:0]    period_q;
    logic [FIELD_W-1:0] low_q;

    logic [SPEED_W-1:0] low_num, high_num, ratio_den;
    logic [2*FIELD_W-1:0] hi_nx, lo_nx, gap_nx;

    logic                 done_q;
    logic                 clamped_q;
    logic [2*FIELD_W-1:0] hi_q, lo_q, gap_q;

    i2c_tcalc_div #(.W(SPEED_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (div_go),
        .dividend (div_dividend),
        .divisor  (div_divisor),
        .quot     (div_quot),
        .rem      (div_rem),
        .valid    (div_valid)
    );

    i2c_tcalc_ratio #(
        .W       (SPEED_W),
        .DIVW    (DIVW),
        .FAST_LO (FAST_LO),
        .FAST_HI (FAST_HI),
        .STD_LO  (STD_LO),
        .STD_HI  (STD_HI)
    ) u_ratio (
        .fast     (fast_q),
        .period   (period_q),
        .low_num  (low_num),
        .high_num (high_num),
        .den      (ratio_den)
    );

    i2c_tcalc_pack #(
        .CW           (FIELD_W),
        .LOW_OVH      (LOW_OVH),
        .HIGH_OVH     (HIGH_OVH),
        .LEADIN_FAST  (LEADIN_FAST),
        .BUSFREE_FAST (BUSFREE_FAST),
        .LEADIN_STD   (LEADIN_STD),
        .BUSFREE_STD  (BUSFREE_STD)
    ) u_pack (
        .fast     (fast_q),
        .low_cnt  (low_q),
        .high_cnt (FIELD_W'(div_quot)),
        .hi_word  (hi_nx),
        .lo_word  (lo_nx),
        .gap_word (gap_nx)
    );

    // Ceiling of the rate division: bump the quotient on a nonzero remainder
    assign period_raw = div_quot + SPEED_W'(div_rem != '0);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CS_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CS_IDLE:     if (start) state_d = (speed_hz == '0) ? CS_SETUP : CS_RATE_DIV;
            CS_RATE_DIV: if (div_valid) state_d = CS_SETUP;
            CS_SETUP:    state_d = CS_LOW_DIV;
            CS_LOW_DIV:  if (div_valid) state_d = CS_HIGH_DIV;
            CS_HIGH_DIV: if (div_valid) state_d = CS_IDLE;
            default:     state_d = CS_IDLE;
        endcase
    end

    // Divider operand selection and launch
    always_comb begin
        div_go       = 1'b0;
        div_dividend = SPEED_W'(CLK_HZ);
        div_divisor  = speed_hz;
        unique case (state_q)
            CS_IDLE: begin
                div_go = start && (speed_hz != '0);
            end
            CS_SETUP: begin
                div_go       = 1'b1;
                div_dividend = low_num;
                div_divisor  = ratio_den;
            end
            CS_LOW_DIV: begin
                div_go       = div_valid;
                div_dividend = high_num;
                div_divisor  = ratio_den;
            end
            default: begin
                div_go = 1'b0;
            end
        endcase
    end

    // Datapath and output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fast_q    <= 1'b0;
            clamp_q   <= 1'b0;
            period_q  <= '0;
            low_q     <= '0;
            done_q    <= 1'b0;
            clamped_q <= 1'b0;
            hi_q      <= '0;
            lo_q      <= '0;
            gap_q     <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                CS_IDLE: begin
                    if (start) begin
                        fast_q <= (speed_hz > SPEED_W'(FAST_ABOVE_HZ));
                        if (speed_hz == '0) begin
                            period_q <= DIVW'(DIV_MAX);
                            clamp_q  <= 1'b1;
                        end
                    end
                end
                CS_RATE_DIV: begin
                    if (div_valid) begin
                        if (period_raw < SPEED_W'(DIV_MIN)) begin
                            period_q <= DIVW'(DIV_MIN);
                            clamp_q  <= 1'b1;
                        end else if (period_raw > SPEED_W'(DIV_MAX)) begin
                            period_q <= DIVW'(DIV_MAX);
                            clamp_q  <= 1'b1;
                        end else begin
                            period_q <= DIVW'(period_raw);
                            clamp_q  <= 1'b0;
                        end
                    end
                end
                CS_LOW_DIV: begin
                    if (div_valid) low_q <= FIELD_W'(div_quot);
                end
                CS_HIGH_DIV: begin
                    if (div_valid) begin
                        hi_q      <= hi_nx;
                        lo_q      <= lo_nx;
                        gap_q     <= gap_nx;
                        clamped_q <= clamp_q;
                        done_q    <= 1'b1;
                    end
                end
                default: begin
                    done_q <= 1'b0;
                end
            endcase
        end
    end

    assign done     = done_q;
    assign clamped  = clamped_q;
    assign hi_word  = hi_q;
    assign lo_word  = lo_q;
    assign gap_word = gap_q;

endmodule

// File: rtl/i2c_tcalc_chk.sv
module i2c_tcalc_chk #(
    parameter int SPEED_W         = 32,
    parameter int FIELD_W         = 16,
    parameter int CLK_HZ          = 24_000_000,
    parameter int DIV_MIN         = 25,
    parameter int DIV_MAX         = 1897,
    parameter int FAST_ABOVE_HZ   = 100_000,
    parameter int LOW_OVH         = 2,
    parameter int HIGH_OVH        = 7,
    parameter int FAST_LEADIN_NS  = 600,
    parameter int FAST_BUSFREE_NS = 1300,
    parameter int STD_LEADIN_NS   = 4700,
    parameter int STD_BUSFREE_NS  = 4700
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start,
    input logic [SPEED_W-1:0]   speed_hz,
    input logic                 done,
    input logic                 clamped,
    input logic [2*FIELD_W-1:0] hi_word,
    input logic [2*FIELD_W-1:0] lo_word,
    input logic [2*FIELD_W-1:0] gap_word
);
    localparam int CLK_MHZ = CLK_HZ / 1_000_000;
    localparam logic [2*FIELD_W-1:0] GAP_FAST = {
        FIELD_W'((FAST_BUSFREE_NS * CLK_MHZ + 999) / 1000),
        FIELD_W'((FAST_LEADIN_NS * CLK_MHZ + 999) / 1000)};
    localparam logic [2*FIELD_W-1:0] GAP_STD = {
        FIELD_W'((STD_BUSFREE_NS * CLK_MHZ + 999) / 1000),
        FIELD_W'((STD_LEADIN_NS * CLK_MHZ + 999) / 1000)};

    logic               pending;
    logic [SPEED_W-1:0] spd_l;
    logic               expect_clamp;

    // Tracks an accepted request and the rate it captured
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
            spd_l   <= '0;
        end else if (start && (!pending || done)) begin
            pending <= 1'b1;
            spd_l   <= speed_hz;
        end else if (done) begin
            pending <= 1'b0;
        end
    end

    always_comb begin
        expect_clamp = (spd_l == '0)
                    || (64'(spd_l) * 64'(DIV_MAX) < 64'(CLK_HZ))
                    || (64'(spd_l) * 64'(DIV_MIN - 1) >= 64'(CLK_HZ));
    end

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_outputs_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable({hi_word, lo_word, gap_word, clamped}));

    p_done_has_request_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> pending);

    p_gap_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (gap_word == ((spd_l > SPEED_W'(FAST_ABOVE_HZ)) ? GAP_FAST : GAP_STD)));

    p_clamp_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (clamped == expect_clamp));

    p_zero_rate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && spd_l == '0) |-> clamped);

    p_rcv_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (int'(hi_word[FIELD_W-1:0]) <= int'(hi_word[2*FIELD_W-1:FIELD_W]) + HIGH_OVH));

    p_xmit_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (int'(lo_word[FIELD_W-1:0]) <= int'(lo_word[2*FIELD_W-1:FIELD_W]) + LOW_OVH));

endmodule

bind i2c_tcalc i2c_tcalc_chk #(
    .SPEED_W         (SPEED_W),
    .FIELD_W         (FIELD_W),
    .CLK_HZ          (CLK_HZ),
    .DIV_MIN         (DIV_MIN),
    .DIV_MAX         (DIV_MAX),
    .FAST_ABOVE_HZ   (FAST_ABOVE_HZ),
    .LOW_OVH         (LOW_OVH),
    .HIGH_OVH        (HIGH_OVH),
    .FAST_LEADIN_NS  (FAST_LEADIN_NS),
    .FAST_BUSFREE_NS (FAST_BUSFREE_NS),
    .STD_LEADIN_NS   (STD_LEADIN_NS),
    .STD_BUSFREE_NS  (STD_BUSFREE_NS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .speed_hz (speed_hz),
    .done     (done),
    .clamped  (clamped),
    .hi_word  (hi_word),
    .lo_word  (lo_word),
    .gap_word (gap_word)
);

// File: tb/sim_i2c_tcalc.sv
module sim_i2c_tcalc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] speed = '0;
    logic        done;
    logic        clamped;
    logic [31:0] hi_word, lo_word, gap_word;

    int n_chk  = 0;
    int n_fail = 0;

    i2c_tcalc u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .speed_hz (speed),
        .done     (done),
        .clamped  (clamped),
        .hi_word  (hi_word),
        .lo_word  (lo_word),
        .gap_word (gap_word)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    // Expected words from the requirements, by plain integer arithmetic
    function automatic void model(input logic [31:0] s, output logic [31:0] w_hi,
                                  output logic [31:0] w_lo, output logic [31:0] w_gap,
                                  output logic cl);
        longint p, lo, hi, rcv, xm, li, bf;
        bit fast;
        p  = (s == 0) ? 64'd1898 : (longint'(24_000_000) + longint'(s) - 1) / longint'(s);
        cl = (p < 25) || (p > 1897);
        if (p < 25)   p = 25;
        if (p > 1897) p = 1897;
        fast = (s > 100_000);
        if (fast) begin
            lo = (p * 13 + 9) / 19;  hi = (p * 6 + 9) / 19;  li = 15;  bf = 32;
        end else begin
            lo = (p * 47 + 43) / 87; hi = (p * 40 + 43) / 87; li = 113; bf = 113;
        end
        rcv = (hi * 3) / 8;
        xm  = (lo * 3) / 8;
        w_hi  = {16'(hi - 7), 16'(rcv)};
        w_lo  = {16'(lo - 2), 16'(xm)};
        w_gap = {16'(bf), 16'(li)};
    endfunction

    task automatic launch(input logic [31:0] s);
        @(negedge clk);
        speed = s;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 1000; i++) begin
            if (done) begin
                seen = 1'b1;
                break;
            end
            @(negedge clk);
        end
    endtask

    // Compare the result at the done cycle, then confirm a one-cycle pulse
    task automatic expect_result(input string req, input logic [31:0] s);
        logic [31:0] e_hi, e_lo, e_gap;
        logic        e_cl;
        bit          seen;
        model(s, e_hi, e_lo, e_gap, e_cl);
        wait_done(seen);
        chk({req, " R9"}, "done seen", 32'(seen), 32'd1);
        chk({req, " R8"}, "hi_word", hi_word, e_hi);
        chk({req, " R8"}, "lo_word", lo_word, e_lo);
        chk({req, " R7"}, "gap_word", gap_word, e_gap);
        chk({req, " R2"}, "clamped", 32'(clamped), 32'(e_cl));
        @(negedge clk);
        chk("R9", "done single cycle", 32'(done), 32'd0);
    endtask

    task automatic run_case(input string req, input logic [31:0] s);
        launch(s);
        expect_result(req, s);
    endtask

    task automatic test_reset();
        chk("R11", "done after reset", 32'(done), 32'd0);
        chk("R11", "clamped after reset", 32'(clamped), 32'd0);
        chk("R11", "hi_word after reset", hi_word, 32'd0);
        chk("R11", "lo_word after reset", lo_word, 32'd0);
        chk("R11", "gap_word after reset", gap_word, 32'd0);
    endtask

    task automatic test_standard();
        run_case("R1 R5 R6", 32'd100_000);
        chk("R5", "low field at 100k", 32'(lo_word[31:16]), 32'd128);
        chk("R6", "receive point at 100k", 32'(hi_word[15:0]), 32'd41);
        run_case("R1 R5 R6", 32'd50_000);
    endtask

    task automatic test_fast();
        run_case("R1 R4 R6", 32'd400_000);
        run_case("R1 R4", 32'd333_333);
    endtask

    task automatic test_mode_edge();
        run_case("R4", 32'd100_001);
        chk("R4", "fast lead-in at 100001", 32'(gap_word[15:0]), 32'd15);
    endtask

    task automatic test_clamp_low();
        run_case("R2", 32'd960_000);
        run_case("R2", 32'd1_000_000);
        run_case("R2", 32'hFFFF_FFFF);
    endtask

    task automatic test_clamp_high();
        run_case("R2", 32'd12_652);
        run_case("R2", 32'd12_651);
        run_case("R2", 32'd1);
    endtask

    task automatic test_zero();
        run_case("R3", 32'd0);
        chk("R3", "clamped on zero rate", 32'(clamped), 32'd1);
        run_case("R2", 32'd400_000);
        chk("R2", "clamp cleared by later request", 32'(clamped), 32'd0);
    endtask

    task automatic test_ignore_start();
        int extra;
        launch(32'd400_000);
        repeat (3) @(negedge clk);
        speed = 32'd100_000;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        expect_result("R10", 32'd400_000);
        extra = 0;
        for (int i = 0; i < 300; i++) begin
            if (done) extra++;
            @(negedge clk);
        end
        chk("R10", "no done for ignored start", 32'(extra), 32'd0);
    endtask

    task automatic test_hold();
        logic [31:0] h0, l0, g0;
        run_case("R9", 32'd250_000);
        h0 = hi_word;
        l0 = lo_word;
        g0 = gap_word;
        repeat (40) @(negedge clk);
        chk("R9", "hi_word held", hi_word, h0);
        chk("R9", "lo_word held", lo_word, l0);
        chk("R9", "gap_word held", gap_word, g0);
    endtask

    initial begin
        repeat (150_000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_standard();
        test_fast();
        test_mode_edge();
        test_clamp_low();
        test_clamp_high();
        test_zero();
        test_ignore_start();
        test_hold();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule